// File: doc/BRIEF.md
# Masked Interrupt Aggregator Registers

This block merges six on-board interrupt sources into one level-sensitive host interrupt line. The sources are a flash serial controller, two I2C masters, two DMA channels and a common-interface controller. Each source raises its own sticky pending bit with a one-cycle set pulse. That bit stays up until the source pulses its own clear input.

A per-source mask selects which pending bits may reach the host. Software never writes the mask as a whole. It changes only through a set alias and a clear alias, where a 1 in a bit position acts on that bit and a 0 leaves it alone. Above the mask sit two further controls. A global enable bit gates the output pin. A separate status bit reports the masked pending term whether or not the enable is on. A host can therefore turn the line off, inspect and service sources, and turn the line back on without losing anything still pending.

All registers sit behind a simple 32-bit register port. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the pending bits, the mask and the global enable are all 0, and `irq_o` is low.
- R2: A 1 on `src_set_i[i]` at a clock edge sets pending bit i, which then stays 1 while its clear input is 0. Bit order is flash=0, I2C0=1, I2C1=2, DMA0=3, DMA1=4, CI=5.
- R3: A 1 on `src_clr_i[i]` clears pending bit i at the edge. If set and clear arrive in the same cycle, the bit ends up 1.
- R4: A write to the mask-set alias (0x68) sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to the mask-clear alias (0x6C) clears every mask bit whose data bit is 1. Writing 0xFFFF there masks every source.
- R6: The global enable register (0x50) holds data bit 7. It reads back as 0x80 when on and 0 when off, with all other bits 0.
- R7: `irq_o` is high exactly when the global enable is 1 and the AND of pending and mask is non-zero.
- R8: The status register (0x40) reads 0x80 whenever the AND of pending and mask is non-zero, independent of the global enable, and reads 0 otherwise.
- R9: The pending register (0x60) and the mask readback (0x64) present bits 5:0 in the R2 order, and bits 31:6 read 0.
- R10: Turning the global enable off and back on while a masked-in source is still pending raises `irq_o` again in the cycle after the enabling write.
- R11: Reads of an unmapped address return 0, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 6 | One-cycle set pulse per source |
| src_clr_i | input | 6 | One-cycle clear pulse per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Aggregated host interrupt, level |

## Verification
The hardest case to reach from the ports is a source that is still pending across a full disable, inspect and re-enable sequence. While the line is off, the status register must still report the pending source. A set pulse landing in the same cycle as its clear must also survive.

A directed sequence builds this case on purpose: it arms a source, unmasks it, drops the enable, reads status, and re-enables. Seeded random traffic then mixes set and clear pulses, alias writes, enable toggles and unmapped writes. After every cycle, every register and the pin are compared against a bench model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum int unsigned {
    SRC_FLASH = 0,
    SRC_I2C0  = 1,
    SRC_I2C1  = 2,
    SRC_DMA0  = 3,
    SRC_DMA1  = 4,
    SRC_CI    = 5
  } src_idx_e;

  localparam int unsigned SRC_COUNT = 6;

  localparam logic [15:0] OFS_GSTAT = 16'h0040;
  localparam logic [15:0] OFS_GEN   = 16'h0050;
  localparam logic [15:0] OFS_PEND  = 16'h0060;
  localparam logic [15:0] OFS_MASK  = 16'h0064;
  localparam logic [15:0] OFS_MSET  = 16'h0068;
  localparam logic [15:0] OFS_MCLR  = 16'h006C;

  typedef struct packed {
    logic gen;
    logic mset;
    logic mclr;
  } wr_strb_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;  // set dominates
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] set_bits, clr_bits;

  assign set_bits = set_we_i ? bits_i : '0;
  assign clr_bits = clr_we_i ? bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLAG_B  = 7
) (
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               gen_i,
  input  logic               hit_i,
  output wr_strb_t           strb_o,
  output logic [NUM_SRC-1:0] src_bits_o,
  output logic               gen_bit_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;
  localparam logic [DATA_W-1:0] FLAG = DATA_W'(1) << FLAG_B;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign src_bits_o = wdata_i[NUM_SRC-1:0];
  assign gen_bit_o  = wdata_i[FLAG_B];

  always_comb begin
    strb_o      = '0;
    strb_o.gen  = we_i && (addr_i == ADDR_W'(OFS_GEN));
    strb_o.mset = we_i && (addr_i == ADDR_W'(OFS_MSET));
    strb_o.mclr = we_i && (addr_i == ADDR_W'(OFS_MCLR));
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_GSTAT): rdata_o = hit_i ? FLAG : '0;
      ADDR_W'(OFS_GEN):   rdata_o = gen_i ? FLAG : '0;
      ADDR_W'(OFS_PEND):  rdata_o = {{PAD_W{1'b0}}, pend_i};
      ADDR_W'(OFS_MASK):  rdata_o = {{PAD_W{1'b0}}, mask_i};
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLAG_B  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [NUM_SRC-1:0] src_clr_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_q, mask_q, src_bits;
  logic               en_q, gen_bit, hit;
  wr_strb_t           strb;

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (src_set_i),
    .clr_i (src_clr_i),
    .pend_o(stat_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(strb.mset),
    .clr_we_i(strb.mclr),
    .bits_i  (src_bits),
    .mask_o  (mask_q)
  );

  irq_reg_if #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_B(FLAG_B)
  ) u_regs (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pend_i    (stat_q),
    .mask_i    (mask_q),
    .gen_i     (en_q),
    .hit_i     (hit),
    .strb_o    (strb),
    .src_bits_o(src_bits),
    .gen_bit_o (gen_bit),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (strb.gen) en_q <= gen_bit;
  end

  assign hit   = |(stat_q & mask_q);
  assign irq_o = en_q & hit;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLAG_B  = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_set_i,
  input logic [NUM_SRC-1:0] src_clr_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               en_q
);
  logic wr_mset, wr_mclr, wr_gen;
  assign wr_mset = reg_we_i && (reg_addr_i == ADDR_W'(16'h0068));
  assign wr_mclr = reg_we_i && (reg_addr_i == ADDR_W'(16'h006C));
  assign wr_gen  = reg_we_i && (reg_addr_i == ADDR_W'(16'h0050));

  assert_set_sticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> ((stat_q & $past(src_set_i)) == $past(src_set_i)));

  assert_clear_works_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(src_clr_i & ~src_set_i)) |=> ((stat_q & $past(src_clr_i & ~src_set_i)) == '0));

  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> ((mask_q & $past(reg_wdata_i[NUM_SRC-1:0])) == $past(reg_wdata_i[NUM_SRC-1:0])));

  assert_mask_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mclr |=> ((mask_q & $past(reg_wdata_i[NUM_SRC-1:0])) == '0));

  assert_mask_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_mset || wr_mclr) |=> $stable(mask_q));

  assert_enable_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gen |=> (en_q == $past(reg_wdata_i[FLAG_B])));

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_q);
endmodule

bind irq_agg_top irq_agg_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_B(FLAG_B)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_set_i  (src_set_i),
  .src_clr_i  (src_clr_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .en_q       (en_q)
);

// File: tb/irq_agg_top_test.sv
`timescale 1ns/1ps
module irq_agg_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  src_set_i = '0, src_clr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] m_pend = '0, m_mask = '0;
  logic       m_en = 1'b0;

  irq_agg_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_set_i(src_set_i), .src_clr_i(src_clr_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] exp_read(logic [15:0] a);
    case (a)
      16'h0040: return (|(m_pend & m_mask)) ? 32'h80 : 32'h0;
      16'h0050: return m_en ? 32'h80 : 32'h0;
      16'h0060: return {26'b0, m_pend};
      16'h0064: return {26'b0, m_mask};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, update the model at the edge
  task automatic cyc(logic [5:0] s, logic [5:0] c, logic we, logic [15:0] a, logic [31:0] d);
    @(negedge clk_i);
    src_set_i = s; src_clr_i = c; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    m_pend = (m_pend & ~c) | s;
    if (we && a == 16'h0068) m_mask = m_mask | d[5:0];
    if (we && a == 16'h006C) m_mask = m_mask & ~d[5:0];
    if (we && a == 16'h0050) m_en = d[7];
    @(negedge clk_i);
    src_set_i = '0; src_clr_i = '0; reg_we_i = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [15:0] addrs [5] = '{16'h0040, 16'h0050, 16'h0060, 16'h0064, 16'h0044};
    #1;
    check({tag, " R7 irq"}, {31'b0, irq_o}, {31'b0, m_en & (|(m_pend & m_mask))});
    foreach (addrs[k]) begin
      reg_addr_i = addrs[k];
      #1;
      check($sformatf("%s R8/R9/R6/R11 rd 0x%0h", tag, addrs[k]), reg_rdata_o, exp_read(addrs[k]));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    check_all("R1");

    // R2 flash source sets and sticks
    cyc(6'b000001, 6'b0, 1'b0, 16'h0, 32'h0);
    check_all("R2 set");
    cyc(6'b0, 6'b0, 1'b0, 16'h0, 32'h0);
    check("R2 sticky", {26'b0, m_pend}, 32'h1);
    check_all("R2 hold");
    // R4 unmask bit0, then set more bits, zeros leave others
    cyc(6'b0, 6'b0, 1'b1, 16'h0068, 32'h1);
    cyc(6'b0, 6'b0, 1'b1, 16'h0068, 32'h28);
    reg_addr_i = 16'h0064; #1;
    check("R4 mask set keeps bit0", reg_rdata_o, 32'h29);
    check_all("R4");
    // R6 enable
    cyc(6'b0, 6'b0, 1'b1, 16'h0050, 32'hFFFF_FF7F);
    check_all("R6 off-bit7");
    cyc(6'b0, 6'b0, 1'b1, 16'h0050, 32'h80);
    check("R7 irq on", {31'b0, irq_o}, 32'h1);
    check_all("R6 on");
    // R10 disable, inspect, re-enable with source pending
    cyc(6'b0, 6'b0, 1'b1, 16'h0050, 32'h0);
    check("R10 irq off while disabled", {31'b0, irq_o}, 32'h0);
    reg_addr_i = 16'h0040; #1;
    check("R8 status while disabled", reg_rdata_o, 32'h80);
    cyc(6'b0, 6'b0, 1'b1, 16'h0050, 32'h80);
    check("R10 irq reasserts", {31'b0, irq_o}, 32'h1);
    // R3 set wins over clear, then clear alone
    cyc(6'b000001, 6'b000001, 1'b0, 16'h0, 32'h0);
    check("R3 set wins", {31'b0, irq_o}, 32'h1);
    cyc(6'b0, 6'b000001, 1'b0, 16'h0, 32'h0);
    check("R3 clear drops irq", {31'b0, irq_o}, 32'h0);
    check_all("R3");
    // R11 unmapped write
    cyc(6'b100000, 6'b0, 1'b1, 16'h0044, 32'hFFFF_FFFF);
    check_all("R11 unmapped");
    // R5 clear all with 0xFFFF
    cyc(6'b0, 6'b0, 1'b1, 16'h006C, 32'hFFFF);
    reg_addr_i = 16'h0064; #1;
    check("R5 mask all cleared", reg_rdata_o, 32'h0);
    check_all("R5");

    // seeded random traffic
    for (int i = 0; i < 400; i++) begin
      logic [5:0] s, c;
      logic we;
      logic [15:0] a;
      logic [31:0] d;
      s = 6'($urandom) & 6'($urandom) & 6'($urandom);
      c = 6'($urandom) & 6'($urandom);
      we = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: a = 16'h0068;
        1: a = 16'h006C;
        2: a = 16'h0050;
        3: a = 16'h0044;
        default: a = 16'h0040;
      endcase
      d = $urandom;
      cyc(s, c, we, a, d);
      check_all("rand");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule